// File: doc/BRIEF.md
# Four-Channel Wiper and Data Register Controller

This block holds the register state behind four digitally set potentiometer channels and carries out the instruction set that a serial front end hands it. Each channel has a volatile 8-bit wiper register that drives the switch decoder. Each channel also has four 8-bit data registers that stand in for nonvolatile storage. The front end delivers a command byte, and for read or write instructions one data byte, each as a single-cycle strobe. The block answers reads with a byte and a strobe.

Writes into the data registers go through a pending buffer and a timed busy period that models the nonvolatile programming time. The new contents become visible only when that period ends. While busy is high the block ignores every command, which lets the front end withhold its acknowledge. A write-protect input, active low, discards every write aimed at the data registers. After reset, each wiper is reloaded from data register 0 of its own channel.

There is also a step mode. In it, single-cycle pulses move one channel's wiper up or down by one position at a time.

Top module: `potbank_ctrl`

## Requirements
- R1: After reset, data register R of channel P holds the byte {P[1:0], R[1:0], 4'b0101}. One cycle after reset is released, every wiper equals data register 0 of its channel (wiper P = {P, 2'b00, 4'b0101}). `busy` and `rd_valid` are low.
- R2: A command byte carries the opcode in bits 7:4, the register pointer R in bits 3:2 and the channel pointer P in bits 1:0. Opcode 1001 returns wiper P on `rd_byte`, and `rd_valid` is high for exactly the one cycle after the command cycle.
- R3: Opcode 1010 arms a wiper write. The next `dat_valid` byte loads wiper P in the cycle it is presented. A `dat_valid` strobe with no armed write is ignored.
- R4: Opcode 1011 returns data register R of channel P on `rd_byte`, with the same timing as R2.
- R5: Opcode 1100 followed by a data byte raises `busy` for exactly BUSY_CYC cycles after the data cycle. The byte lands in data register R of channel P when `busy` falls.
- R6: Opcode 1101 copies data register R of channel P into wiper P. Opcode 0001 copies data register R of every channel into that channel's wiper, and the P field is ignored. Both take effect in the command cycle.
- R7: Opcode 1110 stores wiper P into data register R of channel P. Opcode 1000 stores every wiper into its channel's data register R. Both capture the wipers in the command cycle and follow the busy timing of R5.
- R8: While `prot_n` is low, opcodes 1100, 1110 and 1000 leave every data register unchanged and do not raise `busy`.
- R9: While `busy` is high, command and data strobes change no wiper, produce no read and arm nothing.
- R10: Opcode 0010 enters step mode for channel P. In step mode each cycle with `step_valid` high moves wiper P up by one when `step_up` is 1 and down by one when it is 0, saturating at 255 and 0. Any later command ends step mode.
- R11: Opcodes 0000, 0011 to 0111 and 1111 change no register, produce no read and do not raise `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| prot_n | input | 1 | Data-register write enable; low blocks data-register writes |
| cmd_valid | input | 1 | Command byte strobe |
| cmd_byte | input | 8 | Opcode, register pointer, channel pointer |
| dat_valid | input | 1 | Data byte strobe for an armed write |
| dat_byte | input | W | Data byte |
| step_valid | input | 1 | One wiper step in step mode |
| step_up | input | 1 | Step direction, 1 up, 0 down |
| rd_byte | output | W | Read result |
| rd_valid | output | 1 | Read result strobe |
| busy | output | 1 | Data-register write in progress |
| wiper_pos | output | 4*W | Wiper positions, channel P at bits P*W +: W |

## Verification
The bench sets BUSY_CYC to 20 in place of the half-million-cycle default. With that value, every data-register write and transfer can be followed through its whole busy window, timed to the cycle, within a run of a few thousand cycles. It also allows hundreds of random instructions, including many back-to-back write-then-read sequences on the same register, together with directed attempts to issue commands while busy.

// File: rtl/potbank_pkg.sv
package potbank_pkg;
    localparam int CMD_W = 8;
    localparam int OP_W  = 4;
    localparam int SEL_W = 2;
    localparam int NCH   = 1 << SEL_W;
    localparam int NREG  = 1 << SEL_W;

    localparam logic [OP_W-1:0] OPC_RD_WIPER   = 4'b1001;
    localparam logic [OP_W-1:0] OPC_WR_WIPER   = 4'b1010;
    localparam logic [OP_W-1:0] OPC_RD_DATA    = 4'b1011;
    localparam logic [OP_W-1:0] OPC_WR_DATA    = 4'b1100;
    localparam logic [OP_W-1:0] OPC_DATA2WIPER = 4'b1101;
    localparam logic [OP_W-1:0] OPC_WIPER2DATA = 4'b1110;
    localparam logic [OP_W-1:0] OPC_ALL_D2W    = 4'b0001;
    localparam logic [OP_W-1:0] OPC_ALL_W2D    = 4'b1000;
    localparam logic [OP_W-1:0] OPC_STEP       = 4'b0010;

    typedef enum logic [3:0] {
        K_NONE, K_RD_WIPER, K_WR_WIPER, K_RD_DATA, K_WR_DATA,
        K_D2W, K_W2D, K_ALL_D2W, K_ALL_W2D, K_STEP
    } kind_e;

    typedef struct packed {
        kind_e            kind;
        logic [SEL_W-1:0] rsel;
        logic [SEL_W-1:0] ch;
    } cmd_t;

    typedef enum logic [1:0] {S_RECALL, S_IDLE, S_DATA, S_STEP} state_e;

    // Contents the data registers hold after reset: {channel, register, 0101}.
    function automatic logic [7:0] factory_value(input int ch, input int r);
        logic [1:0] c2;
        logic [1:0] r2;
        c2 = 2'(ch);
        r2 = 2'(r);
        return {c2, r2, 4'b0101};
    endfunction
endpackage

// File: rtl/potbank_decode.sv
module potbank_decode
    import potbank_pkg::*;
(
    input  logic [CMD_W-1:0] cmd_byte,
    output cmd_t             cmd
);
    logic [OP_W-1:0] opc;

    always_comb begin
        opc      = cmd_byte[CMD_W-1 -: OP_W];
        cmd.rsel = cmd_byte[2*SEL_W-1:SEL_W];
        cmd.ch   = cmd_byte[SEL_W-1:0];
        case (opc)
            OPC_RD_WIPER:   cmd.kind = K_RD_WIPER;
            OPC_WR_WIPER:   cmd.kind = K_WR_WIPER;
            OPC_RD_DATA:    cmd.kind = K_RD_DATA;
            OPC_WR_DATA:    cmd.kind = K_WR_DATA;
            OPC_DATA2WIPER: cmd.kind = K_D2W;
            OPC_WIPER2DATA: cmd.kind = K_W2D;
            OPC_ALL_D2W:    cmd.kind = K_ALL_D2W;
            OPC_ALL_W2D:    cmd.kind = K_ALL_W2D;
            OPC_STEP:       cmd.kind = K_STEP;
            default:        cmd.kind = K_NONE;
        endcase
    end
endmodule

// File: rtl/potbank_nvtimer.sv
module potbank_nvtimer #(
    parameter int unsigned CYC = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(CYC + 1);
    localparam logic [CW-1:0] LOAD = CW'(CYC);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start && cnt_q == '0) begin
            cnt_d = LOAD;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);
    assign done = (cnt_q == CW'(1));

    // R5: the count never exceeds the programmed window
    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LOAD);
    // R5: once started, busy stays high until the final cycle of the window
    p_busy_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
endmodule

// File: rtl/potbank_ctrl.sv
module potbank_ctrl
    import potbank_pkg::*;
#(
    parameter int          W        = 8,
    parameter int unsigned BUSY_CYC = 500000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prot_n,
    input  logic             cmd_valid,
    input  logic [CMD_W-1:0] cmd_byte,
    input  logic             dat_valid,
    input  logic [W-1:0]     dat_byte,
    input  logic             step_valid,
    input  logic             step_up,
    output logic [W-1:0]     rd_byte,
    output logic             rd_valid,
    output logic             busy,
    output logic [NCH*W-1:0] wiper_pos
);
    localparam logic [W-1:0] WMAX = '1;

    typedef struct packed {
        state_e                       state;
        logic                         wr_dr;
        logic [SEL_W-1:0]             ch;
        logic [SEL_W-1:0]             rsel;
        logic [NCH-1:0][W-1:0]        wcr;
        logic [NCH-1:0][NREG-1:0][W-1:0] dr;
        logic [NCH-1:0]               pmask;
        logic [SEL_W-1:0]             preg;
        logic [NCH-1:0][W-1:0]        pval;
        logic [W-1:0]                 rd_byte;
        logic                         rd_valid;
    } regs_t;

    function automatic regs_t reset_regs();
        regs_t r;
        r = '0;
        r.state = S_RECALL;
        for (int c = 0; c < NCH; c++) begin
            for (int k = 0; k < NREG; k++) begin
                r.dr[c][k] = W'(factory_value(c, k));
            end
        end
        return r;
    endfunction

    regs_t q, n;
    cmd_t  dc;
    logic  tmr_start, tmr_busy, tmr_done;

    potbank_decode u_dec (
        .cmd_byte (cmd_byte),
        .cmd      (dc)
    );

    potbank_nvtimer #(.CYC(BUSY_CYC)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .busy  (tmr_busy),
        .done  (tmr_done)
    );

    always_comb begin
        n          = q;
        n.rd_valid = 1'b0;
        tmr_start  = 1'b0;

        // Commit pending data-register contents as the busy window closes.
        if (tmr_done) begin
            for (int c = 0; c < NCH; c++) begin
                if (q.pmask[c]) n.dr[c][q.preg] = q.pval[c];
            end
            n.pmask = '0;
        end

        if (q.state == S_RECALL) begin
            for (int c = 0; c < NCH; c++) n.wcr[c] = q.dr[c][0];
            n.state = S_IDLE;
        end else if (!tmr_busy) begin
            if (cmd_valid) begin
                n.state = S_IDLE;
                n.ch    = dc.ch;
                n.rsel  = dc.rsel;
                case (dc.kind)
                    K_RD_WIPER: begin
                        n.rd_byte  = q.wcr[dc.ch];
                        n.rd_valid = 1'b1;
                    end
                    K_RD_DATA: begin
                        n.rd_byte  = q.dr[dc.ch][dc.rsel];
                        n.rd_valid = 1'b1;
                    end
                    K_WR_WIPER: begin
                        n.state = S_DATA;
                        n.wr_dr = 1'b0;
                    end
                    K_WR_DATA: begin
                        n.state = S_DATA;
                        n.wr_dr = 1'b1;
                    end
                    K_D2W: n.wcr[dc.ch] = q.dr[dc.ch][dc.rsel];
                    K_ALL_D2W: begin
                        for (int c = 0; c < NCH; c++) n.wcr[c] = q.dr[c][dc.rsel];
                    end
                    K_W2D: begin
                        if (prot_n) begin
                            n.pmask         = '0;
                            n.pmask[dc.ch]  = 1'b1;
                            n.preg          = dc.rsel;
                            n.pval[dc.ch]   = q.wcr[dc.ch];
                            tmr_start       = 1'b1;
                        end
                    end
                    K_ALL_W2D: begin
                        if (prot_n) begin
                            n.pmask   = '1;
                            n.preg    = dc.rsel;
                            n.pval    = q.wcr;
                            tmr_start = 1'b1;
                        end
                    end
                    K_STEP:  n.state = S_STEP;
                    default: ;
                endcase
            end else if (dat_valid && q.state == S_DATA) begin
                n.state = S_IDLE;
                if (!q.wr_dr) begin
                    n.wcr[q.ch] = dat_byte;
                end else if (prot_n) begin
                    n.pmask       = '0;
                    n.pmask[q.ch] = 1'b1;
                    n.preg        = q.rsel;
                    n.pval[q.ch]  = dat_byte;
                    tmr_start     = 1'b1;
                end
            end else if (step_valid && q.state == S_STEP) begin
                if (step_up && q.wcr[q.ch] != WMAX) begin
                    n.wcr[q.ch] = q.wcr[q.ch] + 1'b1;
                end else if (!step_up && q.wcr[q.ch] != '0) begin
                    n.wcr[q.ch] = q.wcr[q.ch] - 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= reset_regs();
        else        q <= n;
    end

    assign rd_byte   = q.rd_byte;
    assign rd_valid  = q.rd_valid;
    assign busy      = tmr_busy;
    assign wiper_pos = q.wcr;

    logic [W-1:0] cur_wiper;
    assign cur_wiper = q.wcr[q.ch];

    // R5: data registers change only in the cycle the busy window closes
    p_dr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !tmr_done |=> $stable(q.dr));
    // R8: with protection active no new busy window can open
    p_prot_no_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!prot_n && !tmr_busy) |=> !tmr_busy);
    // R2: a read strobe always follows a command strobe
    p_rd_after_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(cmd_valid));
    // R9: commands during busy leave the wipers alone
    p_busy_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_busy && cmd_valid) |=> $stable(q.wcr));
    // R10: an upward step below the top moves the wiper by exactly one
    p_step_up_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == S_STEP && step_valid && step_up && !cmd_valid && !tmr_busy
         && cur_wiper != WMAX) |=> cur_wiper == $past(cur_wiper) + 1'b1);
endmodule

// File: tb/sim_potbank_ctrl.sv
module sim_potbank_ctrl;
    localparam int BUSY = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       prot_n = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [7:0] cmd_byte = '0;
    logic       dat_valid = 1'b0;
    logic [7:0] dat_byte = '0;
    logic       step_valid = 1'b0;
    logic       step_up = 1'b0;
    logic [7:0] rd_byte;
    logic       rd_valid;
    logic       busy;
    logic [31:0] wiper_pos;

    int n_chk = 0;
    int n_err = 0;
    logic [7:0] m_w [4];
    logic [7:0] m_d [4][4];

    always #2 clk = ~clk;

    potbank_ctrl #(.W(8), .BUSY_CYC(BUSY)) u0 (
        .clk(clk), .rst_n(rst_n), .prot_n(prot_n),
        .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
        .dat_valid(dat_valid), .dat_byte(dat_byte),
        .step_valid(step_valid), .step_up(step_up),
        .rd_byte(rd_byte), .rd_valid(rd_valid), .busy(busy),
        .wiper_pos(wiper_pos)
    );

    function automatic logic [7:0] dr_default(input int c, input int r);
        logic [1:0] c2;
        logic [1:0] r2;
        c2 = 2'(c);
        r2 = 2'(r);
        return {c2, r2, 4'b0101};
    endfunction

    function automatic logic [7:0] sat_step(input logic [7:0] v, input logic up);
        if (up) return (v == 8'hFF) ? v : v + 8'd1;
        return (v == 8'h00) ? v : v - 8'd1;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_wipers(input string tag);
        for (int c = 0; c < 4; c++) chk(tag, int'(wiper_pos[c*8 +: 8]), int'(m_w[c]));
    endtask

    task automatic send_cmd(input logic [7:0] b);
        cmd_byte = b; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic send_dat(input logic [7:0] d);
        dat_byte = d; dat_valid = 1'b1;
        @(negedge clk);
        dat_valid = 1'b0;
    endtask

    task automatic count_busy(output int cyc);
        cyc = 0;
        while (busy && cyc < 1000) begin
            cyc++;
            @(negedge clk);
        end
    endtask

    task automatic read_dr_chk(input string tag, input int c, input int r);
        send_cmd({4'b1011, 2'(r), 2'(c)});
        chk(tag, int'(rd_valid), 1);
        chk(tag, int'(rd_byte), int'(m_d[c][r]));
    endtask

    // Executes one instruction of the given kind and updates the model.
    task automatic do_op(input int kind, input int c, input int r,
                         input logic [7:0] v, input logic prot);
        int cyc;
        logic [3:0] bad [7];
        bad = '{4'b0000, 4'b0011, 4'b0100, 4'b0101, 4'b0110, 4'b0111, 4'b1111};
        prot_n = prot;
        case (kind)
            0: begin
                send_cmd({4'b1001, 2'(r), 2'(c)});
                chk("R2 read wiper strobe", int'(rd_valid), 1);
                chk("R2 read wiper value", int'(rd_byte), int'(m_w[c]));
                @(negedge clk);
                chk("R2 read strobe one cycle", int'(rd_valid), 0);
            end
            1: begin
                send_cmd({4'b1010, 2'(r), 2'(c)});
                send_dat(v);
                m_w[c] = v;
            end
            2: read_dr_chk("R4 read data reg", c, r);
            3: begin
                send_cmd({4'b1100, 2'(r), 2'(c)});
                send_dat(v);
                count_busy(cyc);
                chk(prot ? "R5 busy window" : "R8 no busy when protected", cyc, prot ? BUSY : 0);
                if (prot) m_d[c][r] = v;
            end
            4: begin
                send_cmd({4'b1101, 2'(r), 2'(c)});
                m_w[c] = m_d[c][r];
            end
            5: begin
                send_cmd({4'b0001, 2'(r), 2'(c)});
                for (int k = 0; k < 4; k++) m_w[k] = m_d[k][r];
            end
            6: begin
                send_cmd({4'b1110, 2'(r), 2'(c)});
                count_busy(cyc);
                chk(prot ? "R7 busy window" : "R8 no busy when protected", cyc, prot ? BUSY : 0);
                if (prot) m_d[c][r] = m_w[c];
            end
            7: begin
                send_cmd({4'b1000, 2'(r), 2'b00});
                count_busy(cyc);
                chk(prot ? "R7 global busy window" : "R8 global blocked", cyc, prot ? BUSY : 0);
                if (prot) for (int k = 0; k < 4; k++) m_d[k][r] = m_w[k];
            end
            8: begin
                send_cmd({bad[v % 7], 2'(r), 2'(c)});
                chk("R11 no read", int'(rd_valid), 0);
                chk("R11 no busy", int'(busy), 0);
            end
            default: begin
                send_cmd({4'b0010, 2'(r), 2'(c)});
                for (int s = 0; s < int'(v[2:0]) + 1; s++) begin
                    step_up = logic'($urandom_range(0, 1));
                    step_valid = 1'b1;
                    m_w[c] = sat_step(m_w[c], step_up);
                    @(negedge clk);
                end
                step_valid = 1'b0;
            end
        endcase
        prot_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int cyc;
        void'($urandom(32'h0005eed1));
        for (int c = 0; c < 4; c++) begin
            m_w[c] = dr_default(c, 0);
            for (int r = 0; r < 4; r++) m_d[c][r] = dr_default(c, r);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: reset state and power-up recall
        chk("R1 busy low", int'(busy), 0);
        chk("R1 rd_valid low", int'(rd_valid), 0);
        chk_wipers("R1 wipers recalled from register 0");
        for (int c = 0; c < 4; c++)
            for (int r = 0; r < 4; r++) read_dr_chk("R1 default data reg", c, r);

        // R3: stray data strobe is ignored
        send_dat(8'h77);
        chk_wipers("R3 stray data ignored");

        // R10: saturation at both ends, and exit from step mode
        do_op(1, 2, 0, 8'hFE, 1'b1);
        send_cmd(8'b0010_00_10);
        step_up = 1'b1;
        step_valid = 1'b1;
        repeat (3) @(negedge clk);
        step_valid = 1'b0;
        m_w[2] = 8'hFF;
        chk_wipers("R10 saturate at top");
        do_op(1, 2, 0, 8'h01, 1'b1);
        send_cmd(8'b0010_00_10);
        step_up = 1'b0;
        step_valid = 1'b1;
        repeat (3) @(negedge clk);
        step_valid = 1'b0;
        m_w[2] = 8'h00;
        chk_wipers("R10 saturate at bottom");
        send_cmd(8'b1001_00_10);
        step_up = 1'b1;
        step_valid = 1'b1;
        @(negedge clk);
        step_valid = 1'b0;
        chk_wipers("R10 command ends step mode");

        // R9: commands during busy are ignored
        send_cmd(8'b1100_01_00);
        send_dat(8'hA5);
        send_cmd(8'b1010_00_00);
        send_dat(8'h33);
        chk_wipers("R9 wiper write during busy ignored");
        send_cmd(8'b1001_00_00);
        chk("R9 no read during busy", int'(rd_valid), 0);
        count_busy(cyc);
        m_d[0][1] = 8'hA5;
        read_dr_chk("R5 value committed after busy", 0, 1);
        send_dat(8'h44);
        chk_wipers("R9 arm during busy not kept");

        // R8: global store blocked while protected
        do_op(7, 0, 3, 8'h00, 1'b0);
        for (int c = 0; c < 4; c++) read_dr_chk("R8 data regs kept", c, 3);

        // R6/R7: directed global round trip
        do_op(1, 1, 0, 8'h5A, 1'b1);
        do_op(7, 0, 2, 8'h00, 1'b1);
        do_op(1, 1, 0, 8'h00, 1'b1);
        do_op(5, 0, 2, 8'h00, 1'b1);
        chk_wipers("R6 global recall after R7 global store");

        // Random instruction mix
        for (int i = 0; i < 300; i++) begin
            int k;
            int sel;
            logic [7:0] v;
            k   = $urandom_range(0, 9);
            sel = $urandom_range(0, 3);
            v   = (sel == 0) ? 8'hFF : (sel == 1) ? 8'h00 : 8'($urandom);
            do_op(k, $urandom_range(0, 3), $urandom_range(0, 3), v,
                  ($urandom_range(0, 3) != 0));
            chk_wipers("R3 R6 R10 wipers after random op");
        end
        for (int c = 0; c < 4; c++)
            for (int r = 0; r < 4; r++) read_dr_chk("R4 final data reg", c, r);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule